// File: doc/BRIEF.md
# Read Output Pipeline With Selectable Release Timing

This block is the output side of a synchronous burst memory. Each clock edge captures one command: read, write or idle (no command). For a read it takes the word that the array returns in the following cycle and places it on the output data bus. It also generates the enable that turns the bus drivers on and off. Two static strap inputs set the behaviour. The first chooses between bypass timing and registered timing. With bypass timing the array word reaches the pins in the same cycle. With registered timing the word passes through an output flop first. The second strap chooses how long the bus stays driven once the reads stop: a short release or a release one cycle longer.

The command side runs as a stream with no back-pressure. A command is taken on every rising edge, and the pipeline never stalls. So there is no ready signal, and a caller that wants a burst issues one read per cycle. A separate active-low output enable gates the drivers through combinational logic only. The bus model is a data vector plus an enable. The data vector reads as zero whenever the enable is low. This stands for high impedance.

Top module: `rd_out_pipe`

## Requirements
- R1: While reset is asserted, and after it until the first beat is due, dq_oe is 0 and dq_out is 0.
- R2: With ft_bypass=1, a read captured at edge k drives the bus in the cycle after k. In that cycle dq_out equals the rd_data presented in the same cycle.
- R3: With ft_bypass=0, a read captured at edge k drives the bus in the cycle after edge k+1. dq_out then equals the rd_data that was presented between edges k and k+1.
- R4: Reads captured on consecutive edges produce one beat per cycle. The bus stays driven between those beats, and each beat carries its own word.
- R5: With dual_desel=0, the bus is released in the first cycle in which no beat is due. If a non-read is captured at edge m just after a read at m-1, the release comes after edge m with ft_bypass=1 and after edge m+1 with ft_bypass=0.
- R6: With dual_desel=1, the bus stays driven for one more cycle after the last beat and repeats that beat's word. It is released in the cycle after that.
- R7: The command is decoded as follows. cmd_valid=1 with cmd_write=0 is a read. cmd_valid=1 with cmd_write=1 is a write. cmd_valid=0 is idle. A write releases the bus on exactly the same schedule as idle.
- R8: While oe_n=1, dq_oe is 0 and dq_out is 0 at once, with no clock edge needed. When oe_n returns to 0, the pipeline state shows on the bus again.
- R9: With dual_desel=1, a cycle can hold both the extra hold of an older beat and a newer beat. In that case the newer beat's word is driven.
- R10: With both straps at 0, the block gives registered timing with the short release. This is the default configuration.
- R11: dq_out is 0 in every cycle in which dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ft_bypass | input | 1 | Strap: 1 bypass timing, 0 registered timing |
| dual_desel | input | 1 | Strap: 1 release one cycle later, 0 short release |
| cmd_valid | input | 1 | A command is present this edge (0 means idle) |
| cmd_write | input | 1 | With cmd_valid: 1 write, 0 read |
| rd_data | input | DATA_W | Word returned by the array in the cycle after capture |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | DATA_W | Output data (zero when not driven) |
| dq_oe | output | 1 | Bus driver enable |

## Verification
With dual_desel=1, the extra hold of an older beat and a newer beat can both claim the bus in the same cycle. The stimulus provokes this with two reads on consecutive edges. It is judged by checking that the newer word appears, and that the older word does not. Separately, the output enable is toggled right after a release or hold edge, and the bus is sampled inside that same cycle. The bench walks every four-command mix of read, write and idle under all four strap settings. It predicts each cycle's enable and word from capture-to-beat distances computed arithmetically.

// File: rtl/rop_pkg.sv
`timescale 1ns/1ps
package rop_pkg;

  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2
  } cmd_kind_e;

  // taps: capture, output-register stage, one extra stage for long release
  localparam int ROP_TAPS = 3;

  function automatic cmd_kind_e decode_cmd(input logic valid, input logic wr);
    if (!valid)  return CK_IDLE;
    else if (wr) return CK_WRITE;
    else         return CK_READ;
  endfunction

endpackage

// File: rtl/rop_cmd_taps.sv
`timescale 1ns/1ps
module rop_cmd_taps #(
  parameter int TAPS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_read,
  output logic [TAPS-1:0] rd_tap
);
  // rd_tap[i] is 1 when the command captured i edges ago was a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_tap <= '0;
    else        rd_tap <= {rd_tap[TAPS-2:0], is_read};
  end
endmodule

// File: rtl/rop_drive_ctl.sv
`timescale 1ns/1ps
module rop_drive_ctl #(
  parameter int TAPS = 3
) (
  input  logic [TAPS-1:0] rd_tap,
  input  logic            ft_bypass,
  input  logic            dual_desel,
  output logic            drive,
  output logic            live_sel,
  output logic            load
);
  // stage at which a read beat lands: 0 for bypass, 1 for registered
  logic beat_tap;
  logic hold_tap;

  always_comb begin
    if (ft_bypass) begin
      beat_tap = rd_tap[0];
      hold_tap = rd_tap[1];
    end else begin
      beat_tap = rd_tap[1];
      hold_tap = rd_tap[2];
    end
    drive    = beat_tap | (dual_desel & hold_tap);
    // bypass beat shows the array word directly; otherwise the held word
    live_sel = ft_bypass & rd_tap[0];
    load     = rd_tap[0];
  end
endmodule

// File: rtl/rop_data_reg.sv
`timescale 1ns/1ps
module rop_data_reg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              live_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] word_q;

  // one register serves as the registered-timing output flop and the hold copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= rd_data;
  end

  assign data_o = live_sel ? rd_data : word_q;
endmodule

// File: rtl/rd_out_pipe.sv
`timescale 1ns/1ps
module rd_out_pipe #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ft_bypass,
  input  logic              dual_desel,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  import rop_pkg::*;

  localparam int TAPS = ROP_TAPS;

  cmd_kind_e         kind;
  logic              is_read;
  logic [TAPS-1:0]   rd_tap;
  logic              drive;
  logic              live_sel;
  logic              load;
  logic [DATA_W-1:0] data_int;

  assign kind    = decode_cmd(cmd_valid, cmd_write);
  assign is_read = (kind == CK_READ);

  rop_cmd_taps #(.TAPS(TAPS)) u_taps (
    .clk    (clk),
    .rst_n  (rst_n),
    .is_read(is_read),
    .rd_tap (rd_tap)
  );

  rop_drive_ctl #(.TAPS(TAPS)) u_drive (
    .rd_tap    (rd_tap),
    .ft_bypass (ft_bypass),
    .dual_desel(dual_desel),
    .drive     (drive),
    .live_sel  (live_sel),
    .load      (load)
  );

  rop_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .live_sel(live_sel),
    .rd_data (rd_data),
    .data_o  (data_int)
  );

  // asynchronous gate: no flop between oe_n and the pins
  assign dq_oe  = drive & ~oe_n;
  assign dq_out = dq_oe ? data_int : '0;

  // edges completed since reset release, saturating, for the checks below
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  logic rd_cmd;
  assign rd_cmd = cmd_valid & ~cmd_write;

  AST_FLOW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && ft_bypass && $past(rd_cmd)) |-> (drive && data_int == rd_data)); // R2

  AST_PIPE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !ft_bypass && $past(rd_cmd, 2)) |-> (drive && data_int == $past(rd_data))); // R3

  AST_SHORT_RELEASE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && ft_bypass && !dual_desel && !$past(rd_cmd)) |-> !drive); // R5

  AST_SHORT_RELEASE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !ft_bypass && !dual_desel && !$past(rd_cmd, 2)) |-> !drive); // R5

  AST_LONG_HOLD_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && ft_bypass && dual_desel && $past(rd_cmd, 2) && !$past(rd_cmd))
      |-> (drive && $stable(data_int))); // R6

  AST_LONG_HOLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !ft_bypass && dual_desel && $past(rd_cmd, 3) && !$past(rd_cmd, 2))
      |-> (drive && $stable(data_int))); // R6

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && dq_out == '0)); // R8

endmodule

// File: tb/tb_rd_out_pipe.sv
`timescale 1ns/1ps
module tb_rd_out_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 18;
  localparam int NCYC       = 81 * 6 + 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ft_bypass;
  logic              dual_desel;
  logic              cmd_valid;
  logic              cmd_write;
  logic [DATA_W-1:0] rd_data;
  logic              oe_n;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_out_pipe #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .ft_bypass(ft_bypass), .dual_desel(dual_desel),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .rd_data(rd_data),
    .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // command at edge e: 0 idle, 1 read, 2 write; every 4-command mix then 2 idles
  function automatic int cmd_at(input int e);
    int p, j, v;
    if (e < 0) return 0;
    p = e / 6;
    j = e % 6;
    if (p >= 81 || j >= 4) return 0;
    v = p;
    for (int k = 0; k < j; k++) v = v / 3;
    return v % 3;
  endfunction

  function automatic logic [DATA_W-1:0] dgen(input int c, input int m);
    int t;
    t = c * 2749 + m * 40503 + 91;
    return t[DATA_W-1:0];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_cmd(input int c);
    cmd_valid = (c != 0);
    cmd_write = (c == 2);
  endtask

  initial begin
    rst_n = 1'b0; ft_bypass = 1'b0; dual_desel = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; rd_data = '0; oe_n = 1'b0;
    for (int m = 0; m < 4; m++) begin
      rst_n      = 1'b0;
      ft_bypass  = m[0];
      dual_desel = m[1];
      drive_cmd(1);           // a read offered during reset must have no effect
      oe_n       = 1'b0;
      rd_data    = dgen(-7, m);
      repeat (3) @(posedge clk);
      #2;
      check("R1", "reset dq_oe", {31'd0, dq_oe}, 32'd0);
      check("R1", "reset dq_out", {14'd0, dq_out}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      drive_cmd(cmd_at(0));
      rd_data = dgen(-1, m);
      for (int e = 0; e < NCYC; e++) begin
        int depth, span, found, c;
        logic exp_drive, exp_oe;
        logic [DATA_W-1:0] exp_out;
        string tag;
        @(posedge clk);
        #1;
        rd_data = dgen(e, m);
        drive_cmd(cmd_at(e + 1));
        oe_n = ((e % 7) == 5);
        #1;
        depth = m[0] ? 0 : 1;
        span  = m[1] ? 1 : 0;
        found = -1;
        for (int off = depth; off <= depth + span; off++) begin
          if (found < 0 && e - off >= 0 && cmd_at(e - off) == 1) found = off;
        end
        c = e - found;
        exp_drive = (found >= 0);
        exp_oe    = exp_drive && !oe_n;
        exp_out   = exp_oe ? dgen(c, m) : '0;
        if (oe_n && exp_drive)               tag = "R8";
        else if (!exp_drive) begin
          if (e < 2)                         tag = "R1";
          else if (cmd_at(e) == 2)           tag = "R7";
          else                               tag = "R5";
        end
        else if (found > depth)              tag = "R6";
        else if (cmd_at(c - 1) == 1 && m[1]) tag = "R9";
        else if (cmd_at(c - 1) == 1)         tag = "R4";
        else if (m[0])                       tag = "R2";
        else if (m == 0)                     tag = "R10";
        else                                 tag = "R3";
        check(tag, "dq_oe", {31'd0, dq_oe}, {31'd0, exp_oe});
        check(exp_oe ? tag : "R11", "dq_out", {14'd0, dq_out}, {14'd0, exp_out});
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule